// File: doc/BRIEF.md
# Indirect Register Access Target

This block is the target end of a byte-wide management path. An upstream serial bus controller hands it write transactions, each carrying one command byte and one data byte. The block does not give every configuration register its own bus address. It keeps an address pointer instead. One command code loads that pointer. A second command code stores a byte into the register the pointer selects. A third command code starts or halts an embedded controller.

A logical register update therefore takes two bus writes: the pointer first, then the data. The pointer does not advance on its own, so any number of data writes in a row all land on the same location, one after another. Each location also records whether its last update arrived while the embedded firmware was running. A combinational peek port, addressed independently of the pointer, returns both the stored byte and that flag. The peek port lets the surrounding logic, or a testbench, observe the register file.

Top module: `mgmt_indirect_target`

## Requirements
- R1: While `rst` is high on a clock edge, the block reaches this state at that edge: `fw_running` is 1, `addr_ptr` is 0, `cmd_error` is 0, and every location peeks as data 0x00 with its flag at 0.
- R2: A write with command 0x01 loads the data byte into `addr_ptr` at the next clock edge.
- R3: A write with command 0x00 stores the data byte into the location selected by `addr_ptr` at the next clock edge. `peek_data` shows the location at `peek_addr` combinationally.
- R4: The pointer does not auto-increment. It changes only on a command 0x01 write. Back-to-back command 0x00 writes (for example 0x90, 0xB0 and then 0x80 to location 0x06) take effect in order, and the last one remains.
- R5: A write with command 0x80 and data 0x00 sets `fw_running` to 1. Command 0x80 with data 0x01 clears it to 0. Command 0x80 with any other data leaves `fw_running` unchanged and counts as an invalid command under R6.
- R6: A write with any command other than 0x00, 0x01 or 0x80, or an invalid firmware data byte, changes no register, pointer or run state. `cmd_error` is high for exactly the one cycle after that write.
- R7: A command 0x00 write sets the target location's flag to the value `fw_running` had when the write was accepted: 1 if the firmware was running, 0 if it was halted. `peek_live_flag` shows the flag for `peek_addr`.
- R8: While `bus_wr_valid` is low, the command and data inputs have no effect on any state, and `cmd_error` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_valid | input | 1 | One-cycle strobe for a command/data write |
| bus_wr_cmd | input | 8 | Command byte |
| bus_wr_data | input | 8 | Data byte |
| peek_addr | input | ADDR_W | Peek port address |
| peek_data | output | 8 | Byte stored at `peek_addr` |
| peek_live_flag | output | 1 | Written-while-running flag of `peek_addr` |
| fw_running | output | 1 | Embedded firmware run (1) / halt (0) |
| addr_ptr | output | ADDR_W | Current register pointer |
| cmd_error | output | 1 | One-cycle invalid-command pulse |

## Verification
The bench sweeps all 256 locations through pointer-then-data pairs while it alternates the run state. A design that auto-increments the pointer, or that writes to the location the data byte selects, leaves the wrong bytes behind. A design that records a stale run state sets the wrong flags. Three back-to-back writes to location 0x06 expose a design that drops or reorders repeated updates. A sweep of every firmware data byte and every unknown command code catches a design that treats any nonzero data as "stop", a design that lets an invalid write disturb state, and a design whose error pulse is missing or longer than one cycle.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_STORE   = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_POINTER = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_FW_CTRL = 8'h80;

    localparam logic [BYTE_W-1:0] FW_ARG_GO   = 8'h00;
    localparam logic [BYTE_W-1:0] FW_ARG_HALT = 8'h01;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD_PTR,
        OP_STORE,
        OP_FW_GO,
        OP_FW_HALT,
        OP_INVALID
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [BYTE_W-1:0] arg;
    } op_t;

    function automatic op_e classify(input logic valid,
                                     input logic [BYTE_W-1:0] cmd,
                                     input logic [BYTE_W-1:0] data);
        op_e r;
        if (!valid) begin
            r = OP_IDLE;
        end else begin
            case (cmd)
                CMD_STORE:   r = OP_STORE;
                CMD_POINTER: r = OP_LOAD_PTR;
                CMD_FW_CTRL: begin
                    if (data == FW_ARG_GO)        r = OP_FW_GO;
                    else if (data == FW_ARG_HALT) r = OP_FW_HALT;
                    else                          r = OP_INVALID;
                end
                default:     r = OP_INVALID;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
    import mgmt_pkg::*;
(
    input  logic              valid,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] data,
    output op_t               op_out
);

    always_comb begin
        op_out.op  = classify(valid, cmd, data);
        op_out.arg = data;
    end

endmodule

// File: rtl/mgmt_ctrl.sv
module mgmt_ctrl
    import mgmt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_t               op_in,
    output logic [ADDR_W-1:0] ptr,
    output logic              run,
    output logic              err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            run <= 1'b1;
            err <= 1'b0;
        end else begin
            err <= (op_in.op == OP_INVALID);
            case (op_in.op)
                OP_LOAD_PTR: ptr <= op_in.arg[ADDR_W-1:0];
                OP_FW_GO:    run <= 1'b1;
                OP_FW_HALT:  run <= 1'b0;
                default:     ;
            endcase
        end
    end

    // R4: pointer moves only on a pointer load
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (op_in.op != OP_LOAD_PTR) |=> $stable(ptr));

    // R5: start and halt commands
    assert_fw_go_R5: assert property (@(posedge clk) disable iff (rst)
        (op_in.op == OP_FW_GO) |=> run);
    assert_fw_halt_R5: assert property (@(posedge clk) disable iff (rst)
        (op_in.op == OP_FW_HALT) |=> !run);

    // R6: one pulse per invalid write, none otherwise
    assert_err_on_bad_R6: assert property (@(posedge clk) disable iff (rst)
        (op_in.op == OP_INVALID) |=> err);
    assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
        (op_in.op != OP_INVALID) |=> !err);
    assert_err_keeps_run_R6: assert property (@(posedge clk) disable iff (rst)
        (op_in.op == OP_INVALID) |=> $stable(run));

endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import mgmt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_live,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_live
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem  [DEPTH];
    logic [DEPTH-1:0]  live;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            live <= '0;
        end else if (wr_en) begin
            mem[wr_addr]  <= wr_data;
            live[wr_addr] <= wr_live;
        end
    end

    always_comb begin
        rd_data = mem[rd_addr];
        rd_live = live[rd_addr];
    end

    // R3: the stored byte appears at the target location
    assert_store_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

    // R7: the flag captures the run state seen at the write
    assert_live_flag_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (live[$past(wr_addr)] == $past(wr_live)));

endmodule

// File: rtl/mgmt_indirect_target.sv
module mgmt_indirect_target
    import mgmt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_valid,
    input  logic [7:0]        bus_wr_cmd,
    input  logic [7:0]        bus_wr_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data,
    output logic              peek_live_flag,
    output logic              fw_running,
    output logic [ADDR_W-1:0] addr_ptr,
    output logic              cmd_error
);

    op_t op_w;

    mgmt_cmd_decode u_dec (
        .valid  (bus_wr_valid),
        .cmd    (bus_wr_cmd),
        .data   (bus_wr_data),
        .op_out (op_w)
    );

    mgmt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .op_in (op_w),
        .ptr   (addr_ptr),
        .run   (fw_running),
        .err   (cmd_error)
    );

    mgmt_regfile #(.ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op_w.op == OP_STORE),
        .wr_addr (addr_ptr),
        .wr_data (op_w.arg),
        .wr_live (fw_running),
        .rd_addr (peek_addr),
        .rd_data (peek_data),
        .rd_live (peek_live_flag)
    );

    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (fw_running && addr_ptr == '0 && !cmd_error));

    // R8: an idle bus leaves pointer and run state alone
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_valid |=> ($stable(addr_ptr) && $stable(fw_running) && !cmd_error));

endmodule

// File: tb/test_mgmt_indirect_target.sv
`timescale 1ns/1ps
module test_mgmt_indirect_target;

    localparam int AW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          vld;
    logic [7:0]    cmd, dat;
    logic [AW-1:0] paddr;
    logic [7:0]    pdata;
    logic          plive, run, err;
    logic [AW-1:0] ptr;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    logic last_err;

    logic [7:0] exp_mem  [N];
    logic       exp_live [N];
    logic       exp_run;
    logic [7:0] exp_ptr;

    always #2 clk = ~clk;

    mgmt_indirect_target #(.ADDR_W(AW)) i_mgmt_indirect_target (
        .clk(clk), .rst(rst), .bus_wr_valid(vld), .bus_wr_cmd(cmd),
        .bus_wr_data(dat), .peek_addr(paddr), .peek_data(pdata),
        .peek_live_flag(plive), .fw_running(run), .addr_ptr(ptr),
        .cmd_error(err)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] c, input logic [7:0] d);
        @(negedge clk);
        vld = 1'b1; cmd = c; dat = d;
        @(negedge clk);
        vld = 1'b0; cmd = 8'hA5; dat = 8'h3C;
        last_err = err;
    endtask

    task automatic peek_check(input string req, input int a);
        paddr = a[AW-1:0];
        #0.5;
        check(req, $sformatf("data@%0h", a), pdata, exp_mem[a]);
        check(req, $sformatf("flag@%0h", a), plive, exp_live[a]);
    endtask

    task automatic state_check(input string req);
        check(req, "pointer", ptr, exp_ptr);
        check(req, "run", run, exp_run);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; vld = 1'b0; cmd = '0; dat = '0; paddr = '0;
        for (int i = 0; i < N; i++) begin exp_mem[i] = '0; exp_live[i] = 1'b0; end
        exp_run = 1'b1; exp_ptr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        state_check("R1");
        check("R1", "error", err, 0);
        for (int a = 0; a < N; a++) peek_check("R1", a);

        // R8 idle bus with garbage on command/data
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cmd = (k % 2 == 0) ? 8'h00 : 8'h80; dat = 8'(k + 1);
        end
        @(negedge clk);
        state_check("R8");
        check("R8", "error", err, 0);
        peek_check("R8", 0);

        // R2 R3 R7 sweep every location, run state alternating
        for (int a = 0; a < N; a++) begin
            logic [7:0] v;
            v = 8'((a * 29 + 7) & 255);
            if (a % 3 == 0) begin bus_write(8'h80, 8'h01); exp_run = 1'b0; end
            else            begin bus_write(8'h80, 8'h00); exp_run = 1'b1; end
            bus_write(8'h01, 8'(a));
            exp_ptr = 8'(a);
            check("R2", "pointer load", ptr, exp_ptr);
            bus_write(8'h00, v);
            exp_mem[a] = v; exp_live[a] = exp_run;
            check("R3", "no error on store", last_err, 0);
            peek_check("R7", a);
            check("R4", "pointer held after store", ptr, exp_ptr);
        end
        for (int a = 0; a < N; a++) peek_check("R3", a);

        // R4 repeated writes to one location
        bus_write(8'h01, 8'h06); exp_ptr = 8'h06;
        bus_write(8'h00, 8'h90); exp_mem[6] = 8'h90; exp_live[6] = exp_run;
        peek_check("R4", 6);
        bus_write(8'h00, 8'hB0); exp_mem[6] = 8'hB0;
        peek_check("R4", 6);
        bus_write(8'h00, 8'h80); exp_mem[6] = 8'h80;
        peek_check("R4", 6);
        peek_check("R4", 7);
        state_check("R4");

        // R5 firmware data sweep from both run states
        for (int d = 0; d < 256; d++) begin
            for (int s = 0; s < 2; s++) begin
                bus_write(8'h80, (s == 0) ? 8'h00 : 8'h01);
                exp_run = (s == 0);
                bus_write(8'h80, 8'(d));
                if (d == 0) exp_run = 1'b1;
                else if (d == 1) exp_run = 1'b0;
                check("R5", $sformatf("run after data %0h", d), run, exp_run);
                check("R5", $sformatf("error for data %0h", d), last_err, (d > 1) ? 1 : 0);
            end
        end

        // R6 every unknown command code
        bus_write(8'h80, 8'h01); exp_run = 1'b0;
        for (int c = 0; c < 256; c++) begin
            if (c == 0 || c == 1 || c == 8'h80) continue;
            bus_write(8'(c), 8'(c ^ 8'h5A));
            check("R6", $sformatf("error pulse cmd %0h", c), last_err, 1);
            state_check("R6");
            peek_check("R6", 6);
            @(negedge clk);
            check("R6", "pulse ends after one cycle", err, 0);
        end
        peek_check("R6", 8'h5A ^ 8'h02);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule